// File: doc/BRIEF.md
# Prioritized 32-Source Interrupt Controller

This block gathers single-cycle request pulses from 32 interrupt sources into sticky pending flags. It gives each source a two-bit priority level. The level of a source is split across a low-enable word and a high-enable word. Among the pending sources whose level is not zero, the block selects the one with the highest level. When levels are equal, the lowest source number wins. The number of the selected source is offered to the processor core as a 5-bit vector.

Delivery to the core is gated by a 3-bit nesting counter. Interrupts are delivered only while the counter is zero. Software adjusts the counter by writing to one of two strobe words, and the written data is ignored. The core accepts an offered vector with a valid/ready handshake. Acceptance clears the pending flag of that source. It also raises the counter by one, so a handler is not interrupted until it lowers the counter again.

Software reaches the block through a simple bus of 16-bit words. A write completes in the clock cycle in which `bus_sel` and `bus_we` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The word offsets are as follows: 0 and 1 are low-enable for sources 0–15 and 16–31, 2 and 3 are high-enable for the same halves, 4 and 5 are the pending words for the same halves, 6 is the selected-vector word (read-only), 7 is the counter (its low 3 bits can be read and written), 8 is the disable strobe and 9 is the enable strobe. After reset every word reads 0 and `irq_valid` is 0. The strobe words and any unmapped offset read 0.
- R2: Source n uses bit n mod 16 of the word of its half. Its level is the pair {high-enable bit, low-enable bit}. 00 means masked, 01 is level 1, 10 is level 2 and 11 is level 3, the lowest to the highest.
- R3: A request pulse on `src_req[n]` sets pending bit n at that clock edge. The bit stays set whatever the level of the source, including masked, until it is cleared.
- R4: A write to a pending word clears each bit written as 0 and leaves each bit written as 1 unchanged. A hardware request for the same bit in the same cycle wins, and the bit stays set.
- R5: The candidate is the pending source with the highest non-zero level. Among equal levels the lowest number wins. Word 6 reads the candidate's number. When there is no candidate, word 6 reads the last vector offered, which is 0 after reset.
- R6: A write to word 8 raises the counter by one and saturates at 7. A write to word 9 lowers it by one and saturates at 0. A write to word 7 loads the low 3 bits of the written data.
- R7: `irq_valid` rises at the clock edge that follows a cycle in which the counter is 0 and a candidate exists. It never rises while the counter is non-zero.
- R8: While `irq_valid` is high and `irq_ready` is low, `irq_valid` and `irq_vector` hold. At the accepting edge, the pending bit of the offered source clears, the counter rises by one (saturating), and `irq_valid` falls.
- R9: If a new request for the offered source arrives in the same cycle as the acceptance, the pending bit of that source stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| src_req | input | 32 | Request pulses, one bit per source |
| irq_valid | output | 1 | Vector offered to the core |
| irq_ready | input | 1 | Core accepts the offered vector |
| irq_vector | output | 5 | Offered source number |

## Verification
Register writes and request pulses take effect at the edge on which they are sampled. The bench therefore reads registers back at the next falling edge. `irq_valid` is due one edge after a pending bit is set, or one edge after the counter reaches zero. The bench checks that it is still low at the first falling edge and high at the second. The acceptance takes effect at the edge on which `irq_ready` is sampled. So `irq_valid` is checked as low, and the pending word and the counter are read back, at the following falling edge. The candidate choice is sampled combinationally through word 6 while the counter is held non-zero, so that no delivery disturbs the pending state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 16;
  localparam int LVL_W  = 2;

  localparam logic [ADDR_W-1:0] OFF_ENLO = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_ENHI = 4'd2;
  localparam logic [ADDR_W-1:0] OFF_PEND = 4'd4;
  localparam logic [ADDR_W-1:0] OFF_VEC  = 4'd6;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 4'd7;
  localparam logic [ADDR_W-1:0] OFF_DIS  = 4'd8;
  localparam logic [ADDR_W-1:0] OFF_ENA  = 4'd9;

  typedef logic [LVL_W-1:0] level_t;
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int NSRC   = 32,
  parameter int WORD_W = 16,
  parameter int IDX_W  = $clog2(NSRC),
  localparam int NWORD = NSRC / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [NWORD-1:0]  word_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic [NSRC-1:0]   flags
);
  logic [NSRC-1:0] keep_mask;
  logic [NSRC-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign keep_mask[w*WORD_W +: WORD_W] = word_wr[w] ? wdata : {WORD_W{1'b1}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & keep_mask & ~clr_mask) | src_req;
  end

  // R3/R4/R9: every request lands, whatever clears hit the same cycle
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req != '0) |=> ((flags & $past(src_req)) == $past(src_req)));
  // R3: with no write and no acceptance, no pending bit is lost
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr == '0 && !clr_en) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  en_lo,
  input  logic [NSRC-1:0]  en_hi,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  level_t lvl [NSRC];
  level_t best;

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    assign lvl[i] = pend[i] ? {en_hi[i], en_lo[i]} : '0;
  end

  // strict compare keeps the first (lowest) index on equal levels
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (lvl[i] > best) begin
        best = lvl[i];
        idx  = IDX_W'(i);
        any  = 1'b1;
      end
    end
  end

  // R5: a chosen source is pending and not masked
  always_comb begin
    if (any) a_r5_pick_valid: assert (pend[idx] && (en_hi[idx] || en_lo[idx]));
  end
endmodule

// File: rtl/irq_nest_counter.sv
module irq_nest_counter #(
  parameter int CNT_W = 3,
  localparam int CMAX = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_bus,
  input  logic             dec_bus,
  input  logic             inc_ack,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  int sum;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    sum = int'(cnt) + int'(inc_bus) + int'(inc_ack) - int'(dec_bus);
    if (sum > CMAX) sum = CMAX;
    if (sum < 0)    sum = 0;
    nxt = load ? load_val : CNT_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  a_r6_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(CMAX) && inc_bus && !dec_bus && !load) |=> cnt == CNT_W'(CMAX));
  a_r6_sat_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && dec_bus && !inc_bus && !inc_ack && !load) |=> cnt == '0);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int CNT_W = 3,
  localparam int IDX_W = $clog2(NSRC),
  localparam int NWORD = NSRC / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_req,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [IDX_W-1:0]  irq_vector
);
  logic             wr;
  logic [NSRC-1:0]  en_lo, en_hi, pend;
  logic [NWORD-1:0] pend_wr;
  logic             cand_any;
  logic [IDX_W-1:0] cand_idx;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign wr     = bus_sel && bus_we;
  assign accept = irq_valid && irq_ready;

  for (genvar w = 0; w < NWORD; w++) begin : g_en
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(OFF_ENLO + w);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(OFF_ENHI + w);
    localparam logic [ADDR_W-1:0] A_PD = ADDR_W'(OFF_PEND + w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_lo[w*WORD_W +: WORD_W] <= '0;
        en_hi[w*WORD_W +: WORD_W] <= '0;
      end else if (wr) begin
        if (bus_addr == A_LO) en_lo[w*WORD_W +: WORD_W] <= bus_wdata;
        if (bus_addr == A_HI) en_hi[w*WORD_W +: WORD_W] <= bus_wdata;
      end
    end
    assign pend_wr[w] = wr && bus_addr == A_PD;
  end

  irq_pending_bank #(.NSRC(NSRC), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .word_wr(pend_wr),
    .wdata(bus_wdata), .clr_en(accept), .clr_idx(irq_vector), .flags(pend)
  );

  irq_level_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .pend(pend), .en_lo(en_lo), .en_hi(en_hi), .any(cand_any), .idx(cand_idx)
  );

  irq_nest_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .inc_bus(wr && bus_addr == OFF_DIS),
    .dec_bus(wr && bus_addr == OFF_ENA),
    .inc_ack(accept),
    .load(wr && bus_addr == OFF_CNT),
    .load_val(bus_wdata[CNT_W-1:0]),
    .cnt(cnt)
  );

  // offer stage: vector frozen from offer until acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else if (!irq_valid) begin
      if (cnt == '0 && cand_any) begin
        irq_valid  <= 1'b1;
        irq_vector <= cand_idx;
      end
    end else if (irq_ready) begin
      irq_valid <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      for (int w = 0; w < NWORD; w++) begin
        if (bus_addr == ADDR_W'(OFF_ENLO + w)) bus_rdata = en_lo[w*WORD_W +: WORD_W];
        if (bus_addr == ADDR_W'(OFF_ENHI + w)) bus_rdata = en_hi[w*WORD_W +: WORD_W];
        if (bus_addr == ADDR_W'(OFF_PEND + w)) bus_rdata = pend[w*WORD_W +: WORD_W];
      end
      if (bus_addr == OFF_VEC) bus_rdata = WORD_W'(cand_any ? cand_idx : irq_vector);
      if (bus_addr == OFF_CNT) bus_rdata = WORD_W'(cnt);
    end
  end

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && cnt != '0) |=> !irq_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_vector)));
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !irq_valid);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !src_req[irq_vector]) |=> !pend[$past(irq_vector)]);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [31:0] src_req = '0;
  logic        irq_valid;
  logic        irq_ready = 0;
  logic [4:0]  irq_vector;

  int errs = 0, checks = 0;
  bit done = 0;
  logic [15:0] sh_lo [2];
  logic [15:0] sh_hi [2];
  int last_del = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 4'(a);
    #1 d = int'(bus_rdata);
    bus_sel = 0;
  endtask

  task automatic pulse(logic [31:0] m);
    @(negedge clk); src_req = m;
    @(negedge clk); src_req = '0;
  endtask

  task automatic set_level(int n, int lv);
    sh_lo[n/16][n%16] = lv[0];
    sh_hi[n/16][n%16] = lv[1];
    wr(0 + n/16, sh_lo[n/16]);
    wr(2 + n/16, sh_hi[n/16]);
  endtask

  task automatic accept_now();
    @(negedge clk); irq_ready = 1;
    @(negedge clk); irq_ready = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int d;
    sh_lo[0] = 0; sh_lo[1] = 0; sh_hi[0] = 0; sh_hi[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      rd(a, d); chk($sformatf("R1 reset word %0d", a), d, 0);
    end
    chk("R1 valid after reset", int'(irq_valid), 0);

    // R2/R3/R7/R8 sweep over every source
    for (int n = 0; n < 32; n++) begin
      set_level(n, (n % 3) + 1);
      pulse(32'(1) << n);
      chk("R7 valid not yet", int'(irq_valid), 0);
      @(negedge clk);
      chk("R7 valid due", int'(irq_valid), 1);
      chk("R2 vector", int'(irq_vector), n);
      rd(4 + n/16, d);
      chk("R3 pending bit", d, 1 << (n % 16));
      @(negedge clk);
      chk("R8 hold valid", int'(irq_valid), 1);
      chk("R8 hold vector", int'(irq_vector), n);
      accept_now();
      last_del = n;
      chk("R8 valid falls", int'(irq_valid), 0);
      rd(4 + n/16, d); chk("R8 pending cleared", d, 0);
      rd(7, d); chk("R8 counter raised", d, 1);
      wr(9, 0);
      set_level(n, 0);
    end

    // R3 masked source keeps its pending bit
    pulse(32'(1) << 7);
    repeat (3) @(negedge clk);
    chk("R3 masked no valid", int'(irq_valid), 0);
    rd(4, d); chk("R3 masked pending", d, 1 << 7);
    set_level(7, 2);
    @(negedge clk);
    chk("R3 unmask delivers", int'(irq_valid), 1);
    chk("R3 unmask vector", int'(irq_vector), 7);
    accept_now(); last_del = 7;
    set_level(7, 0);
    wr(9, 0);

    // R6 counter saturation and load
    for (int k = 0; k < 9; k++) wr(8, 16'hFFFF);
    rd(7, d); chk("R6 sat at 7", d, 7);
    for (int k = 0; k < 9; k++) wr(9, 16'hFFFF);
    rd(7, d); chk("R6 sat at 0", d, 0);
    wr(7, 16'hFFF5);
    rd(7, d); chk("R6 load", d, 5);
    wr(7, 1);

    // R4 software clear and set-wins
    pulse(32'h000C_0004);
    rd(4, d); chk("R4 pend lo", d, 4);
    rd(5, d); chk("R4 pend hi", d, 12);
    wr(5, 16'hFFFB);
    rd(5, d); chk("R4 clear by 0", d, 8);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 4; bus_wdata = 0; src_req = 32'h4;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; src_req = '0;
    rd(4, d); chk("R4 request wins", d, 4);
    wr(4, 0); wr(5, 0);
    rd(4, d); chk("R4 cleared lo", d, 0);
    rd(5, d); chk("R4 cleared hi", d, 0);

    // R5 level/tie sweep with delivery held off (counter = 1)
    for (int p = 0; p < 2; p++) begin
      int a = (p == 0) ? 3 : 5;
      int b = (p == 0) ? 20 : 6;
      for (int la = 0; la < 4; la++) begin
        for (int lb = 0; lb < 4; lb++) begin
          int e;
          set_level(a, la); set_level(b, lb);
          pulse((32'(1) << a) | (32'(1) << b));
          if (la == 0 && lb == 0) e = last_del;
          else if (la > lb) e = a;
          else if (lb > la) e = b;
          else e = (a < b) ? a : b;
          rd(6, d);
          chk($sformatf("R5 pick a=%0d lb=%0d", la, lb), d, e);
          chk("R7 held off", int'(irq_valid), 0);
          wr(4, 0); wr(5, 0);
        end
      end
      set_level(a, 0); set_level(b, 0);
    end

    // R9 request during acceptance survives
    wr(9, 0);
    set_level(12, 3);
    pulse(32'(1) << 12);
    @(negedge clk);
    chk("R9 offered", int'(irq_vector), 12);
    @(negedge clk); irq_ready = 1; src_req = 32'(1) << 12;
    @(negedge clk); irq_ready = 0; src_req = '0;
    rd(4, d); chk("R9 pending kept", d, 1 << 12);
    rd(7, d); chk("R9 counter", d, 1);
    wr(9, 0);
    chk("R7 not before next edge", int'(irq_valid), 0);
    @(negedge clk);
    chk("R7 redelivered", int'(irq_valid), 1);
    chk("R7 redelivered vector", int'(irq_vector), 12);
    accept_now();
    rd(4, d); chk("R8 final clear", d, 0);

    finish_run();
  end
endmodule